// File: doc/BRIEF.md
# Serial Memory Bus Slave Front End

This block is the bus-facing half of a small byte-wide nonvolatile memory. It is a serial-bus slave. It takes chip select, serial clock, serial data in and an active-low pause input, and it oversamples them all in the system clock domain. A transaction has three parts in order: an 8-bit instruction, a fixed number of address bytes, and then any number of data bytes. The block turns each received byte into a one-cycle strobe on a parallel interface. A downstream controller owns command meaning, the storage array, status and write timing, and it decides from the opcode whether the data bytes are writes or reads.

For reads, the block raises a request at every byte boundary in the data phase. The controller answers with a one-cycle load of the next byte, and the block shifts that byte out most significant bit first. The serial input is sampled on falling clock edges, and the serial output changes only after rising edges. The output enable is low whenever the slave is deselected or paused.

Top module: `spi_mem_frontend`

## Requirements
- R1: On each falling serial clock edge while selected and not paused, one bit of `si` is taken, most significant bit first. The first 8 bits after chip select falls form the instruction, presented on `op_code` with a one-cycle `op_valid`.
- R2: The next ADDR_BYTES bytes are joined into `addr`, first byte in the most significant position, and presented with one `addr_valid` pulse after the last address byte.
- R3: Every byte after the address is presented on `wr_data` with a one-cycle `wr_valid`.
- R4: `rd_req` pulses once when the address completes and once after each data byte. A byte given on `rd_data` with `rd_load` before the next rising serial clock edge is shifted out on `so`, most significant bit first, one bit per rising edge. `so` changes only after a rising edge or on deselection, and `so_oe` is high while data bytes are being transferred.
- R5: While `cs_n` is high, `so_oe` is low and the transaction state returns to the instruction phase.
- R6: After reset, no strobe is produced until `cs_n` has been seen going from high to low.
- R7: A pause starts only when `hold_n` falls while the serial clock is high, and ends only when `hold_n` rises while the serial clock is high. Changes of `hold_n` while the serial clock is low have no effect.
- R8: While paused, `sclk` and `si` are ignored, the bit position is kept, and `so_oe` is low.
- R9: Raising `cs_n` in the middle of a byte discards the partial byte, and the next selection starts again with the instruction.
- R10: Each of `op_valid`, `addr_valid`, `wr_valid` and `rd_req` is high for exactly one system clock cycle per event.
- R11: If the serial clock stops for any length of time while selected, all bit and byte state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| op_valid | output | 1 | Instruction byte strobe |
| op_code | output | 8 | Last received instruction |
| addr_valid | output | 1 | Address complete strobe |
| addr | output | 8*ADDR_BYTES | Assembled address |
| wr_valid | output | 1 | Data byte received strobe |
| wr_data | output | 8 | Last received data byte |
| rd_req | output | 1 | Request for the next byte to send |
| rd_load | input | 1 | Load strobe for `rd_data` |
| rd_data | input | 8 | Byte to be shifted out |

## Verification
The bench builds the block with ADDR_BYTES=2 and SYNC_STAGES=2. Two address bytes exercise the multi-byte address path, including the carry of the first byte into the upper half and the move into the data phase after the counter reaches its last value. With two synchronizer stages, the latency from a pin edge to a strobe stays short against the eight-cycle serial half period. That margin lets the bench load read data in the gap between a byte boundary and the next rising edge. It also makes pauses, clock stops and mid-byte deselection land at known points within a byte.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_ADDR   = 2'd1,
    PH_DATA   = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_fe_rst_sync.sv
module spi_fe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '0;
      else        ff_q <= {ff_q[STAGES-2:0], d[g]};
    end
    assign q[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sclk_s,
  input  logic hold_s,
  output logic paused
);
  logic hold_q;
  logic paused_q, paused_d;
  logic hold_fall, hold_rise;

  always_comb begin
    hold_fall = hold_q & ~hold_s;
    hold_rise = ~hold_q & hold_s;
    paused_d  = paused_q;
    if (!enable)                                  paused_d = 1'b0;
    else if (!paused_q && hold_fall && sclk_s)    paused_d = 1'b1;
    else if (paused_q && hold_rise && sclk_s)     paused_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      hold_q   <= hold_s;
      paused_q <= paused_d;
    end
  end

  assign paused = paused_q;
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift
  import spi_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fall,
  input  logic              rise,
  input  logic              si,
  input  logic              tx_en,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              so
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] pend_q, pend_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    rx_d   = rx_q;
    tx_d   = tx_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (load) pend_d = load_data;
    if (clear) begin
      rx_d  = '0;
      tx_d  = '0;
      cnt_d = '0;
    end else begin
      if (fall) begin
        rx_d  = {rx_q[BYTE_W-2:0], si};
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      if (rise && tx_en) begin
        // A new byte starts at the first rising edge of each byte slot.
        tx_d = (cnt_q == '0) ? pend_q : {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      tx_q   <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
    end else begin
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rx_byte   = {rx_q[BYTE_W-2:0], si};
  assign byte_done = fall & ~clear & (cnt_q == LAST);
  assign bit_cnt   = cnt_q;
  assign so        = tx_q[BYTE_W-1];
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int ADDR_BYTES  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = BYTE_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic              op_valid,
  output logic [BYTE_W-1:0] op_code,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  input  logic              rd_load,
  input  logic [BYTE_W-1:0] rd_data
);
  localparam int AC_W = $clog2(ADDR_BYTES + 1);
  localparam logic [AC_W-1:0] ADDR_LAST = AC_W'(ADDR_BYTES - 1);

  logic rst_n_s;
  logic cs_s, sclk_s, si_s, hold_s;
  logic cs_q, sclk_q;
  logic armed_q, armed_d;
  logic sel, paused, go;
  logic sclk_fall, sclk_rise;
  logic [BYTE_W-1:0] rx_byte;
  logic byte_done;
  logic [CNT_W-1:0] bit_cnt;

  phase_e            phase_q, phase_d;
  logic [AC_W-1:0]   acnt_q, acnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] op_q, op_d, wd_q, wd_d;
  logic              opv_q, opv_d, adv_q, adv_d, wrv_q, wrv_d, rq_q, rq_d;
  logic              oe_q, oe_d;

  spi_fe_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  spi_fe_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_pin_sync (
    .clk(clk), .rst_n(rst_n_s),
    .d({cs_n, sclk, si, hold_n}),
    .q({cs_s, sclk_s, si_s, hold_s})
  );

  spi_fe_hold i_hold (
    .clk(clk), .rst_n(rst_n_s), .enable(sel),
    .sclk_s(sclk_s), .hold_s(hold_s), .paused(paused)
  );

  spi_fe_shift i_shift (
    .clk(clk), .rst_n(rst_n_s), .clear(~sel),
    .fall(sclk_fall), .rise(sclk_rise), .si(si_s),
    .tx_en(phase_q == PH_DATA),
    .load(rd_load), .load_data(rd_data),
    .rx_byte(rx_byte), .byte_done(byte_done),
    .bit_cnt(bit_cnt), .so(so)
  );

  // Edge qualification: selection needs a prior high-to-low on chip select.
  always_comb begin
    armed_d   = armed_q | (cs_q & ~cs_s);
    sel       = armed_q & ~cs_s;
    go        = sel & ~paused;
    sclk_fall = go & sclk_q & ~sclk_s;
    sclk_rise = go & ~sclk_q & sclk_s;
  end

  // Byte sequencing: instruction, address bytes, then data bytes.
  always_comb begin
    phase_d = phase_q;
    acnt_d  = acnt_q;
    addr_d  = addr_q;
    op_d    = op_q;
    wd_d    = wd_q;
    opv_d   = 1'b0;
    adv_d   = 1'b0;
    wrv_d   = 1'b0;
    rq_d    = 1'b0;
    if (!sel) begin
      phase_d = PH_OPCODE;
      acnt_d  = '0;
    end else if (byte_done) begin
      unique case (phase_q)
        PH_OPCODE: begin
          op_d    = rx_byte;
          opv_d   = 1'b1;
          phase_d = PH_ADDR;
        end
        PH_ADDR: begin
          addr_d = (addr_q << BYTE_W) | ADDR_W'(rx_byte);
          acnt_d = acnt_q + 1'b1;
          if (acnt_q == ADDR_LAST) begin
            adv_d   = 1'b1;
            rq_d    = 1'b1;
            phase_d = PH_DATA;
          end
        end
        default: begin
          wd_d  = rx_byte;
          wrv_d = 1'b1;
          rq_d  = 1'b1;
        end
      endcase
    end
    oe_d = sel & ~paused & (phase_q == PH_DATA);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cs_q    <= 1'b0;
      sclk_q  <= 1'b0;
      armed_q <= 1'b0;
      phase_q <= PH_OPCODE;
      acnt_q  <= '0;
      addr_q  <= '0;
      op_q    <= '0;
      wd_q    <= '0;
      opv_q   <= 1'b0;
      adv_q   <= 1'b0;
      wrv_q   <= 1'b0;
      rq_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      cs_q    <= cs_s;
      sclk_q  <= sclk_s;
      armed_q <= armed_d;
      phase_q <= phase_d;
      acnt_q  <= acnt_d;
      addr_q  <= addr_d;
      op_q    <= op_d;
      wd_q    <= wd_d;
      opv_q   <= opv_d;
      adv_q   <= adv_d;
      wrv_q   <= wrv_d;
      rq_q    <= rq_d;
      oe_q    <= oe_d;
    end
  end

  assign so_oe      = oe_q;
  assign op_valid   = opv_q;
  assign op_code    = op_q;
  assign addr_valid = adv_q;
  assign addr       = addr_q;
  assign wr_valid   = wrv_q;
  assign wr_data    = wd_q;
  assign rd_req     = rq_q;
endmodule

// File: rtl/spi_mem_frontend_chk.sv
module spi_mem_frontend_chk
  import spi_fe_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_s,
  input logic             sclk_s,
  input logic             armed,
  input logic             sel,
  input logic             paused,
  input logic             sclk_rise,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             so,
  input logic             so_oe,
  input logic             op_valid,
  input logic             addr_valid,
  input logic             wr_valid,
  input logic             rd_req
);
  a_r10_op_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);
  a_r10_addr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !addr_valid);
  a_r10_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  a_r10_rq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r5_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_oe);
  a_r6_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!op_valid && !addr_valid && !wr_valid && !rd_req));
  a_r7_pause_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(sclk_s));
  a_r7_pause_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> ($past(sclk_s) || !$past(sel)));
  a_r8_paused_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    paused |=> !so_oe);
  a_r8_position_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !cs_s) |=> $stable(bit_cnt));
  a_r4_so_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> ($past(sclk_rise) || !$past(sel)));
endmodule

bind spi_mem_frontend spi_mem_frontend_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s),
  .armed(armed_q), .sel(sel), .paused(paused), .sclk_rise(sclk_rise),
  .bit_cnt(bit_cnt), .so(so), .so_oe(so_oe), .op_valid(op_valid),
  .addr_valid(addr_valid), .wr_valid(wr_valid), .rd_req(rd_req)
);

// File: tb/test_spi_mem_frontend.sv
module test_spi_mem_frontend;
  localparam int ADDR_BYTES = 2;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, si, hold_n, rd_load;
  logic [7:0] rd_data;
  logic so, so_oe, op_valid, addr_valid, wr_valid, rd_req;
  logic [7:0] op_code, wr_data;
  logic [8*ADDR_BYTES-1:0] addr;

  int n_vec = 0, n_err = 0;
  int n_op = 0, n_addr = 0, n_wr = 0, n_rq = 0, n_wide = 0;
  logic [7:0] last_op = '0, last_wr = '0;
  logic [15:0] last_addr = '0;
  logic p_op = 0, p_ad = 0, p_wr = 0, p_rq = 0;
  logic pause_oe, got_oe;

  // op, address, data, is_write, mode (0 plain, 1 pause in opcode,
  // 2 hold toggled with clock low, 3 long clock stop, 4 pause in read data)
  localparam logic [35:0] VEC [6] = '{
    {8'h02, 16'h0000, 8'h5A, 1'b1, 3'd0},
    {8'h03, 16'h01FF, 8'hC3, 1'b0, 3'd0},
    {8'h0A, 16'h8001, 8'hFF, 1'b1, 3'd1},
    {8'h0B, 16'h1234, 8'h96, 1'b0, 3'd4},
    {8'h02, 16'hFFFF, 8'h01, 1'b1, 3'd2},
    {8'h03, 16'h00A5, 8'h7E, 1'b0, 3'd3}
  };

  spi_mem_frontend #(.ADDR_BYTES(ADDR_BYTES), .SYNC_STAGES(2)) i_spi_mem_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe), .op_valid(op_valid),
    .op_code(op_code), .addr_valid(addr_valid), .addr(addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_load(rd_load), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (op_valid)   begin n_op++;   last_op = op_code; end
      if (addr_valid) begin n_addr++; last_addr = addr; end
      if (wr_valid)   begin n_wr++;   last_wr = wr_data; end
      if (rd_req)     n_rq++;
      if ((op_valid && p_op) || (addr_valid && p_ad) ||
          (wr_valid && p_wr) || (rd_req && p_rq)) n_wide++;
      p_op = op_valid; p_ad = addr_valid; p_wr = wr_valid; p_rq = rd_req;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, input int m, output logic got);
    if (m == 2) begin hold_n = 1'b0; wait_h(); end
    sclk = 1'b1; si = b; wait_h();
    if (m == 1 || m == 4) begin
      hold_n = 1'b0; wait_h(); wait_h();
      pause_oe = so_oe;
      for (int k = 0; k < 3; k++) begin
        sclk = 1'b0; si = ~b; wait_h();
        sclk = 1'b1; wait_h();
      end
      si = b; hold_n = 1'b1; wait_h(); wait_h();
    end
    if (m == 3) repeat (3000) @(negedge clk);
    got = so; got_oe = so_oe;
    sclk = 1'b0; wait_h();
    if (m == 2) begin hold_n = 1'b1; wait_h(); end
  endtask

  task automatic xfer_byte(input logic [7:0] b, input int m, output logic [7:0] got);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(b[i], (i == 4) ? m : 0, g);
      got[i] = g;
    end
  endtask

  task automatic load_rd(input logic [7:0] d);
    rd_data = d; rd_load = 1'b1;
    @(negedge clk);
    rd_load = 1'b0;
  endtask

  task automatic txn(input logic [7:0] op, input logic [15:0] a,
                     input logic [7:0] d, input logic wr, input int m);
    int b_op, b_ad, b_wr, b_rq;
    logic [7:0] got;
    b_op = n_op; b_ad = n_addr; b_wr = n_wr; b_rq = n_rq;
    cs_n = 1'b0; wait_h();
    xfer_byte(op, (m == 4) ? 0 : m, got);
    for (int j = ADDR_BYTES - 1; j >= 0; j--) xfer_byte(a[8*j +: 8], 0, got);
    if (wr) xfer_byte(d, 0, got);
    else begin
      load_rd(d);
      xfer_byte(8'h00, (m == 4) ? 4 : 0, got);
    end
    wait_h();
    chk(n_op == b_op + 1 && last_op == op, "R1 opcode", last_op, op);
    chk(n_addr == b_ad + 1 && last_addr == a, "R2 address", last_addr, a);
    if (wr) chk(n_wr == b_wr + 1 && last_wr == d, "R3 write data", last_wr, d);
    else begin
      chk(got == d, "R4 read data", got, d);
      chk(got_oe == 1'b1, "R4 output enabled in data", got_oe, 1);
      chk(n_rq == b_rq + 2, "R4 read requests", n_rq - b_rq, 2);
    end
    if (m == 1 || m == 4) begin
      chk(pause_oe == 1'b0, "R8 hi-z while paused", pause_oe, 0);
      chk(last_op == op, "R8 bit position kept over pause", last_op, op);
    end
    if (m == 2) chk(last_op == op, "R7 hold with clock low ignored", last_op, op);
    if (m == 3) chk(last_addr == a, "R11 static clock state kept", last_addr, a);
    cs_n = 1'b1; wait_h(); wait_h();
    chk(so_oe == 1'b0, "R5 deselected hi-z", so_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [7:0] got;
    rst_n = 1'b0; cs_n = 1'b0; sclk = 1'b0; si = 1'b0; hold_n = 1'b1;
    rd_load = 1'b0; rd_data = '0;
    repeat (5) @(negedge clk);
    chk(so_oe == 1'b0 && op_valid == 1'b0 && rd_req == 1'b0,
        "R5 reset state", {so_oe, op_valid, rd_req}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R6: chip select low since power-up, never seen falling
    xfer_byte(8'hA5, 0, got);
    xfer_byte(8'h3C, 0, got);
    xfer_byte(8'h11, 0, got);
    wait_h();
    chk(n_op == 0 && n_addr == 0, "R6 no activity before first select", n_op, 0);
    chk(so_oe == 1'b0, "R6 output off before first select", so_oe, 0);
    cs_n = 1'b1; wait_h();

    for (int v = 0; v < 6; v++)
      txn(VEC[v][35:28], VEC[v][27:12], VEC[v][11:4], VEC[v][3], int'(VEC[v][2:0]));

    // R9: partial byte then deselect
    begin
      int b_op;
      logic g;
      b_op = n_op;
      cs_n = 1'b0; wait_h();
      xfer_bit(1'b1, 0, g); xfer_bit(1'b0, 0, g);
      xfer_bit(1'b1, 0, g); xfer_bit(1'b0, 0, g);
      cs_n = 1'b1; wait_h(); wait_h();
      chk(n_op == b_op, "R9 partial byte discarded", n_op, b_op);
      txn(8'h06, 16'h4321, 8'hE7, 1'b1, 0);
      chk(n_op == b_op + 1 && last_op == 8'h06, "R9 restart at instruction", last_op, 8'h06);
    end

    chk(n_wide == 0, "R10 single-cycle strobes", n_wide, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule